// File: doc/BRIEF.md
# Exception Entry Sequencer

This controller sits next to a small CPU core and takes over whenever the core must enter exception handling. It watches three causes: the release of the reset input, a maskable interrupt request, and a strobe that the core raises when it executes a trap instruction. It decides which cause to serve and then carries out the entry steps through a simple request/acknowledge memory port. The core stays stalled for the whole entry.

For an interrupt or a trap, the sequencer first saves the program counter and the condition code byte on a downward-growing stack. It then commands the core to set the interrupt mask bit and hands back the lowered stack pointer. Next it reads a handler address from a vector table and gives that address to the core as the new program counter. Reset entry leaves out the stack save and performs only the mask set and the vector fetch.

Reset has the highest priority, interrupts come second and traps come last. When several causes are present together, they are served one entry after another.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `mem_req`, `set_mask`, `sp_load` and `pc_load` are 0. After `rst_n` rises, a reset entry runs. It sets the mask, reads the vector at address 0, loads the word read into `pc_new`, and performs no stack write and no `sp_load`.
- R2: An interrupt is entered only when the sequencer is idle, `irq_req` and `insn_boundary` are both 1, and mask bit 7 of `cur_ccr` is 0. Otherwise the request is not taken and `busy` stays 0.
- R3: When the sequencer is idle, a `trap_strobe` pulse starts a trap entry whatever the values of `insn_boundary` and the mask bit.
- R4: A trap strobe that arrives while `busy` is 1 is held. Its entry starts right after the current entry finishes, with the operand it carried.
- R5: If an interrupt is eligible in the same cycle as a trap, the interrupt entry runs first and the trap entry follows.
- R6: Interrupt and trap entries write the PC word to address SP-2 first, then the CCR (zero-extended, in the low byte) to address SP-4. `sp_load` presents SP-4 on `sp_new`.
- R7: `set_mask` pulses for one cycle. In interrupt and trap entries this pulse comes after both stack writes have been acknowledged, and in every entry it comes before the vector read.
- R8: The vector is read at address number×4. An interrupt uses `irq_num`, a trap uses 8+`trap_op` and reset uses 0. The word read appears on `pc_new` with a one-cycle `pc_load` pulse.
- R9: Once raised, `mem_req` stays high with a stable address, data and direction until `mem_ack`.
- R10: `busy` is 1 from the cycle after an entry is accepted until the cycle after `pc_load`. No memory request or core command occurs while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its rising edge starts the reset entry |
| irq_req | input | 1 | Maskable interrupt request |
| irq_num | input | NUM_W | Vector number of the requesting interrupt |
| insn_boundary | input | 1 | Core has finished its current instruction |
| trap_strobe | input | 1 | Trap instruction executed |
| trap_op | input | 2 | Trap operand |
| cur_pc | input | AW | Core program counter |
| cur_ccr | input | CCR_W | Core condition code byte |
| cur_sp | input | AW | Core stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| busy | output | 1 | Stall for the core |
| set_mask | output | 1 | Command: set CCR mask bit |
| sp_load | output | 1 | Command: load `sp_new` |
| sp_new | output | AW | Lowered stack pointer |
| pc_load | output | 1 | Command: load `pc_new` |
| pc_new | output | AW | Handler address |

## Verification
A wrong state in this block shows up at the memory port within one entry. The symptoms are a missing or reordered stack write, a vector read at the wrong address, or an entry started while the core had no boundary or had the mask set. A lost or stuck trap-pending flag shows up as a missing second entry, or an extra one, in the few dozen cycles after a busy period. The bench logs every write, read and command in order, using memory latencies of one and three cycles. It compares this log against sequences derived from the captured PC, CCR and SP.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_MASK,
        ST_VEC,
        ST_LOAD
    } seq_st_e;

    typedef enum logic [1:0] {
        EK_RESET,
        EK_IRQ,
        EK_TRAP
    } exc_kind_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int NUM_W     = 6,
    parameter int TRAP_BASE = 8
) (
    input  logic                    idle,
    input  logic                    irq_req,
    input  logic [NUM_W-1:0]        irq_num,
    input  logic                    boundary,
    input  logic                    masked,
    input  logic                    trap_now,
    input  logic [1:0]              trap_op_now,
    input  logic                    trap_pend,
    input  logic [1:0]              trap_op_pend,
    output logic                    take,
    output exc_pkg::exc_kind_e      take_kind,
    output logic [NUM_W-1:0]        take_num,
    output logic                    trap_used
);
    logic       irq_ok;
    logic       trap_any;
    logic [1:0] op_sel;

    always_comb begin
        irq_ok    = idle && irq_req && boundary && !masked;
        trap_any  = trap_now || trap_pend;
        op_sel    = trap_pend ? trap_op_pend : trap_op_now;
        take      = irq_ok || (idle && trap_any);
        trap_used = idle && !irq_ok && trap_any;
        if (irq_ok) begin
            take_kind = exc_pkg::EK_IRQ;
            take_num  = irq_num;
        end else begin
            take_kind = exc_pkg::EK_TRAP;
            take_num  = NUM_W'(TRAP_BASE) + NUM_W'(op_sel);
        end
    end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
    parameter int NUM_W = 6,
    parameter int AW    = 16,
    parameter int SH    = 2
) (
    input  logic [NUM_W-1:0] num,
    output logic [AW-1:0]    vec_addr
);
    localparam int PADW = AW - NUM_W - SH;

    generate
        if (PADW > 0) begin : g_pad
            assign vec_addr = {{PADW{1'b0}}, num, {SH{1'b0}}};
        end else begin : g_nopad
            assign vec_addr = {num, {SH{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/exc_stack_unit.sv
module exc_stack_unit #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CCR_W      = 8,
    parameter int SLOT_BYTES = 2
) (
    input  logic [AW-1:0]    sp_base,
    input  logic [AW-1:0]    pc,
    input  logic [CCR_W-1:0] ccr,
    input  logic             sel_ccr,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    data,
    output logic [AW-1:0]    sp_final
);
    localparam logic [AW-1:0] SLOT = AW'(SLOT_BYTES);

    logic [DW-1:0] pc_ext;
    logic [DW-1:0] ccr_ext;

    generate
        if (DW > AW) begin : g_pc_wide
            assign pc_ext = {{(DW-AW){1'b0}}, pc};
        end else begin : g_pc_same
            assign pc_ext = pc;
        end
        if (DW > CCR_W) begin : g_ccr_wide
            assign ccr_ext = {{(DW-CCR_W){1'b0}}, ccr};
        end else begin : g_ccr_same
            assign ccr_ext = ccr;
        end
    endgenerate

    always_comb begin
        sp_final = sp_base - (SLOT << 1);
        addr     = sel_ccr ? sp_final : (sp_base - SLOT);
        data     = sel_ccr ? ccr_ext : pc_ext;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CCR_W      = 8,
    parameter int MASK_BIT   = 7,
    parameter int NUM_W      = 6,
    parameter int TRAP_BASE  = 8,
    parameter int SLOT_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [NUM_W-1:0] irq_num,
    input  logic             insn_boundary,
    input  logic             trap_strobe,
    input  logic [1:0]       trap_op,
    input  logic [AW-1:0]    cur_pc,
    input  logic [CCR_W-1:0] cur_ccr,
    input  logic [AW-1:0]    cur_sp,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             set_mask,
    output logic             sp_load,
    output logic [AW-1:0]    sp_new,
    output logic             pc_load,
    output logic [AW-1:0]    pc_new
);
    import exc_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        exc_kind_e        kind;
        logic [NUM_W-1:0] num;
        logic [AW-1:0]    pc;
        logic [CCR_W-1:0] ccr;
        logic [AW-1:0]    sp;
        logic             tpend;
        logic [1:0]       top;
        logic [AW-1:0]    newpc;
    } seq_t;

    seq_t q, d;

    logic             take;
    exc_kind_e        take_kind;
    logic [NUM_W-1:0] take_num;
    logic             trap_used;
    logic [AW-1:0]    vec_addr;
    logic [AW-1:0]    stk_addr;
    logic [DW-1:0]    stk_data;
    logic [AW-1:0]    stk_final;

    exc_arbiter #(.NUM_W(NUM_W), .TRAP_BASE(TRAP_BASE)) u_arb (
        .idle         (q.st == ST_IDLE),
        .irq_req      (irq_req),
        .irq_num      (irq_num),
        .boundary     (insn_boundary),
        .masked       (cur_ccr[MASK_BIT]),
        .trap_now     (trap_strobe),
        .trap_op_now  (trap_op),
        .trap_pend    (q.tpend),
        .trap_op_pend (q.top),
        .take         (take),
        .take_kind    (take_kind),
        .take_num     (take_num),
        .trap_used    (trap_used)
    );

    exc_vec_gen #(.NUM_W(NUM_W), .AW(AW), .SH(2)) u_vec (
        .num      (q.num),
        .vec_addr (vec_addr)
    );

    exc_stack_unit #(.AW(AW), .DW(DW), .CCR_W(CCR_W), .SLOT_BYTES(SLOT_BYTES)) u_stk (
        .sp_base  (q.sp),
        .pc       (q.pc),
        .ccr      (q.ccr),
        .sel_ccr  (q.st == ST_PUSH_CCR),
        .addr     (stk_addr),
        .data     (stk_data),
        .sp_final (stk_final)
    );

    // next-state computation
    always_comb begin
        d = q;
        case (q.st)
            ST_BOOT: begin
                d.st   = ST_MASK;
                d.kind = EK_RESET;
                d.num  = '0;
            end
            ST_IDLE: begin
                if (take) begin
                    d.st   = ST_PUSH_PC;
                    d.kind = take_kind;
                    d.num  = take_num;
                    d.pc   = cur_pc;
                    d.ccr  = cur_ccr;
                    d.sp   = cur_sp;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ack) d.st = ST_PUSH_CCR;
            end
            ST_PUSH_CCR: begin
                if (mem_ack) d.st = ST_MASK;
            end
            ST_MASK: begin
                d.st = ST_VEC;
            end
            ST_VEC: begin
                if (mem_ack) begin
                    d.newpc = mem_rdata[AW-1:0];
                    d.st    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        // trap holding slot
        if (trap_used) begin
            if (q.tpend && trap_strobe) begin
                d.tpend = 1'b1;
                d.top   = trap_op;
            end else begin
                d.tpend = 1'b0;
            end
        end else if (trap_strobe && !q.tpend) begin
            d.tpend = 1'b1;
            d.top   = trap_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_BOOT;
            q.kind  <= EK_RESET;
        end else begin
            q <= d;
        end
    end

    // outputs decoded from registered state
    always_comb begin
        busy      = (q.st != ST_IDLE);
        mem_req   = (q.st == ST_PUSH_PC) || (q.st == ST_PUSH_CCR) || (q.st == ST_VEC);
        mem_we    = (q.st == ST_PUSH_PC) || (q.st == ST_PUSH_CCR);
        mem_addr  = (q.st == ST_VEC) ? vec_addr : (mem_we ? stk_addr : '0);
        mem_wdata = mem_we ? stk_data : '0;
        set_mask  = (q.st == ST_MASK);
        sp_load   = (q.st == ST_MASK) && (q.kind != EK_RESET);
        sp_new    = stk_final;
        pc_load   = (q.st == ST_LOAD);
        pc_new    = q.newpc;
    end

    // R9: a raised request holds its address, data and direction until acknowledged
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    // R7: in a stacking entry the mask command follows an acknowledged write
    assert_mask_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask && sp_load) |-> $past(mem_req && mem_we && mem_ack));

    // R7: the vector read follows the mask command
    assert_vec_after_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |=> (mem_req && !mem_we));

    // R10: nothing reaches memory or the core while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || set_mask || pc_load || sp_load));

    // R2: an entry not caused by a trap needs an unmasked request at a boundary
    assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(trap_strobe) && !$past(q.tpend))
            |-> $past(irq_req && insn_boundary && !cur_ccr[MASK_BIT]));

    // R8: core commands and memory traffic never overlap
    assert_cmd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_load, set_mask, mem_req}));

endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [5:0]  irq_num = '0;
    logic        insn_boundary = 1'b0;
    logic        trap_strobe = 1'b0;
    logic [1:0]  trap_op = '0;
    logic [15:0] pc_m = '0;
    logic [7:0]  ccr_m = '0;
    logic [15:0] sp_m = '0;
    logic        mem_req, mem_we, busy, set_mask, sp_load, pc_load;
    logic [15:0] mem_addr, mem_wdata, sp_new, pc_new;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    // event log: 1 write, 2 mask, 3 read, 4 pc load
    int          ev_k [16];
    logic [15:0] ev_a [16];
    logic [15:0] ev_d [16];
    int          nev = 0;
    int          sp_loads = 0;
    int          lat = 1;
    int          wcnt = 0;
    logic [15:0] hold_a = '0;
    logic [15:0] hold_d = '0;
    bit          req_bad = 0;
    bit          busy_bad = 0;

    always #10 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
        .insn_boundary(insn_boundary), .trap_strobe(trap_strobe), .trap_op(trap_op),
        .cur_pc(pc_m), .cur_ccr(ccr_m), .cur_sp(sp_m),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .set_mask(set_mask),
        .sp_load(sp_load), .sp_new(sp_new), .pc_load(pc_load), .pc_new(pc_new)
    );

    // rows: {is_trap, irq_num, trap_op, pc, ccr, sp}
    localparam logic [48:0] TBL [4] = '{
        {1'b0, 6'd5,  2'd0, 16'h1234, 8'h05, 16'h7F00},
        {1'b1, 6'd0,  2'd0, 16'h2222, 8'h81, 16'h7E00},
        {1'b1, 6'd0,  2'd3, 16'h0ABC, 8'h00, 16'h7D10},
        {1'b0, 6'd63, 2'd0, 16'hFFFE, 8'h3C, 16'h6000}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic log_ev(input int k, input logic [15:0] a, input logic [15:0] dd);
        if (nev < 16) begin
            ev_k[nev] = k; ev_a[nev] = a; ev_d[nev] = dd;
        end
        nev++;
        if (!busy) busy_bad = 1;
    endtask

    task automatic clear_log();
        nev = 0; sp_loads = 0;
    endtask

    // one clock: observe outputs, model the core and the memory
    task automatic tick();
        @(negedge clk);
        if (set_mask) begin ccr_m[7] = 1'b1; log_ev(2, 16'h0, 16'h0); end
        if (sp_load)  begin sp_m = sp_new; sp_loads++; end
        if (pc_load)  begin pc_m = pc_new; log_ev(4, 16'h0, pc_new); end
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt == 0) begin
                hold_a = mem_addr; hold_d = mem_wdata;
            end else if (mem_addr !== hold_a || mem_wdata !== hold_d) begin
                req_bad = 1;
            end
            wcnt++;
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack = 1'b1;
                if (mem_we) log_ev(1, mem_addr, mem_wdata);
                else begin
                    mem_rdata = 16'h4000 | mem_addr;
                    log_ev(3, mem_addr, 16'h0);
                end
            end
        end else if (wcnt != 0) begin
            req_bad = 1; wcnt = 0;
        end
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        for (int i = 0; i < 300 && quiet < 3; i++) begin
            tick();
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic check_entry(input int b, input logic [5:0] num, input logic [15:0] pc,
                               input logic [7:0] ccr, input logic [15:0] sp);
        logic [15:0] va;
        va = {8'h00, num, 2'b00};
        chk("R6 first write kind", ev_k[b],   1);
        chk("R6 pc write addr",    ev_a[b],   sp - 16'd2);
        chk("R6 pc write data",    ev_d[b],   pc);
        chk("R6 ccr write kind",   ev_k[b+1], 1);
        chk("R6 ccr write addr",   ev_a[b+1], sp - 16'd4);
        chk("R6 ccr write data",   ev_d[b+1], {8'h00, ccr});
        chk("R7 mask after push",  ev_k[b+2], 2);
        chk("R8 vector read kind", ev_k[b+3], 3);
        chk("R8 vector address",   ev_a[b+3], va);
        chk("R8 pc load kind",     ev_k[b+4], 4);
        chk("R8 pc load value",    ev_d[b+4], 16'h4000 | va);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
        $finish;
    end

    initial begin
        // R1: held in reset
        repeat (3) tick();
        chk("R1 busy in reset", busy, 1);
        chk("R1 no request in reset", {mem_req, set_mask, sp_load, pc_load}, 4'b0);
        clear_log();
        pc_m = 16'h0100; sp_m = 16'h8000; ccr_m = 8'h00;
        rst_n = 1'b1;
        wait_quiet();
        chk("R1 reset event count", nev, 3);
        chk("R1 mask first", ev_k[0], 2);
        chk("R1 vector read", ev_k[1], 3);
        chk("R1 vector addr 0", ev_a[1], 16'h0000);
        chk("R1 pc load", ev_d[2], 16'h4000);
        chk("R1 no sp load", sp_loads, 0);
        chk("R1 mask set", ccr_m[7], 1);

        // stimulus table
        for (int i = 0; i < 4; i++) begin
            logic [48:0] r;
            logic [5:0]  num;
            r = TBL[i];
            lat = (i % 2 == 1) ? 3 : 1;
            pc_m = r[39:24]; ccr_m = r[23:16]; sp_m = r[15:0];
            clear_log();
            if (r[48]) begin
                insn_boundary = 1'b0; trap_strobe = 1'b1; trap_op = r[41:40];
                num = 6'd8 + {4'd0, r[41:40]};
            end else begin
                insn_boundary = 1'b1; irq_req = 1'b1; irq_num = r[47:42];
                num = r[47:42];
            end
            tick();
            trap_strobe = 1'b0; irq_req = 1'b0; insn_boundary = 1'b0;
            wait_quiet();
            chk(r[48] ? "R3 trap entry taken" : "R2 irq entry taken", nev, 5);
            check_entry(0, num, r[39:24], r[23:16], r[15:0]);
            chk("R6 sp returned", sp_m, r[15:0] - 16'd4);
            chk("R7 mask bit set", ccr_m[7], 1);
        end
        lat = 1;
        chk("R9 request held until ack", req_bad, 0);

        // R2: no boundary
        clear_log();
        ccr_m = 8'h00; irq_req = 1'b1; irq_num = 6'd7; insn_boundary = 1'b0;
        repeat (6) tick();
        chk("R2 no entry without boundary", nev, 0);
        chk("R2 busy low without boundary", busy, 0);
        // R2: masked
        ccr_m = 8'h80; insn_boundary = 1'b1;
        repeat (6) tick();
        chk("R2 no entry when masked", nev, 0);
        chk("R2 busy low when masked", busy, 0);
        irq_req = 1'b0; insn_boundary = 1'b0;

        // R4: trap during busy is held
        clear_log();
        pc_m = 16'h1000; ccr_m = 8'h00; sp_m = 16'h7000;
        irq_req = 1'b1; irq_num = 6'd2; insn_boundary = 1'b1;
        tick();
        irq_req = 1'b0; insn_boundary = 1'b0;
        tick();
        chk("R10 busy after accept", busy, 1);
        trap_strobe = 1'b1; trap_op = 2'd2;
        tick();
        trap_strobe = 1'b0;
        wait_quiet();
        chk("R4 two entries", nev, 10);
        check_entry(0, 6'd2, 16'h1000, 8'h00, 16'h7000);
        check_entry(5, 6'd10, 16'h4008, 8'h80, 16'h6FFC);
        chk("R4 final sp", sp_m, 16'h6FF8);

        // R5: interrupt beats trap in the same cycle
        clear_log();
        pc_m = 16'h3000; ccr_m = 8'h02; sp_m = 16'h7400;
        irq_req = 1'b1; irq_num = 6'd1; insn_boundary = 1'b1;
        trap_strobe = 1'b1; trap_op = 2'd1;
        tick();
        irq_req = 1'b0; insn_boundary = 1'b0; trap_strobe = 1'b0;
        wait_quiet();
        chk("R5 two entries", nev, 10);
        chk("R5 irq vector first", ev_a[3], 16'h0004);
        check_entry(0, 6'd1, 16'h3000, 8'h02, 16'h7400);
        check_entry(5, 6'd9, 16'h4004, 8'h82, 16'h73FC);

        chk("R10 events only while busy", busy_bad, 0);
        chk("R10 idle at end", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule